// File: doc/BRIEF.md
# Delay-Slot Result Writeback Scheduler

This block times the execute and writeback stage of a core that issues at most one instruction per clock. Each issued instruction names a latency class, a destination in one of two 32-word register files, a result value, a branch target and a predicate. The block holds every result until the delay slots of its class have passed, and only then writes it into the register file. There is no interlock. An instruction that reads a destination while a result for it is still pending sees the value the register held before.

A branch does not redirect fetch at once. It raises a one-cycle redirect pulse carrying its target only after its delay slots have elapsed. Several branches may be in flight, and each fires on its own schedule in issue order. A combinational read port returns committed register contents, so the delay-slot behaviour can be observed from outside. A result is made of a valid bit, a file select, an index and a value. Pending results travel down one shift lane per delayed class, and the four possible commits of a cycle are merged into the register file by issue age.

Top module: `dslot_wb_sched`

## Requirements
- R1: An instruction issued in cycle t with class code 0 (single-cycle) and a true predicate is readable on the read port from cycle t+1.
- R2: Class code 1 (integer or fast multiply) has one delay slot. Reads in cycle t+1 return the old value, and reads from cycle t+2 return the new one.
- R3: Class code 2 (slow floating multiply) has two delay slots. The old value is read in cycles t+1 and t+2, and the new one from t+3.
- R4: Class code 3 (load) has four delay slots. The old value is read in cycles t+1 to t+4, and the new one from t+5.
- R5: A branch (class code 4) issued in cycle t with a true predicate drives redir_valid high for exactly cycle t+6, with redir_addr equal to its iss_target. redir_valid is low in cycles t+1 to t+5.
- R6: An issue with iss_pred low, with iss_valid low, or with a class code of 5, 6 or 7 changes no register and causes no redirect.
- R7: When several results commit to the same register at the same clock edge, the one issued last is kept.
- R8: iss_file/rd_file value 0 selects file A and value 1 selects file B. The same index in A and in B names two independent registers.
- R9: Branches issued in cycles t and t+2 produce separate redirect pulses in cycles t+6 and t+8, each with its own target, and no pulse in t+7.
- R10: After reset every register reads zero and redir_valid is low.
- R11: Pending results of different classes aimed at different registers all commit, each at its own time, without disturbing one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_cls | input | 3 | Latency class code (0 single, 1 multiply, 2 slow float multiply, 3 load, 4 branch) |
| iss_pred | input | 1 | Predicate outcome; low squashes the instruction |
| iss_file | input | 1 | Destination file select (0 = A, 1 = B) |
| iss_idx | input | 5 | Destination register index |
| iss_data | input | 32 | Result value to be written |
| iss_target | input | 32 | Branch target address |
| rd_file | input | 1 | Read port file select |
| rd_idx | input | 5 | Read port register index |
| rd_data | output | 32 | Committed contents of the selected register |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_addr | output | 32 | Redirect target address |

## Verification
The hardest case to reach is a single commit edge on which three or four results land on one register. Such a collision only happens when instructions of different classes are issued at staggered cycles, so that their delays end together. The stimulus issues a load, then a slow multiply two cycles later, then a plain multiply one cycle after that, all to the same register. It checks that the register keeps its old value through the shared delay window and then holds the multiply's value. A second case lines up a load with a single-cycle instruction issued four cycles later to the same register. Back-to-back branches two cycles apart test that pending redirects stay separate and in order.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int IDX_W    = $clog2(NREG);
    localparam int CLS_W    = 3;

    localparam int DLY_MUL  = 1;
    localparam int DLY_FMUL = 2;
    localparam int DLY_LOAD = 4;
    localparam int DLY_BR   = 5;

    // Delayed write lanes, ordered by ascending delay.
    localparam int NLANE    = 3;
    localparam int NWP      = NLANE + 1;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU       = 3'd0,
        CLS_IMUL      = 3'd1,
        CLS_FMUL_SLOW = 3'd2,
        CLS_LOAD      = 3'd3,
        CLS_BRANCH    = 3'd4
    } iss_cls_e;

    typedef struct packed {
        logic             vld;
        logic             file;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  val;
    } wb_entry_t;

    function automatic int lane_delay(input int lane);
        case (lane)
            0:       return DLY_MUL;
            1:       return DLY_FMUL;
            default: return DLY_LOAD;
        endcase
    endfunction

    function automatic logic [CLS_W-1:0] lane_class(input int lane);
        case (lane)
            0:       return CLS_IMUL;
            1:       return CLS_FMUL_SLOW;
            default: return CLS_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/dsw_lane.sv
module dsw_lane
    import dsw_pkg::*;
#(
    parameter int DELAY = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  wb_entry_t in_e,
    output wb_entry_t out_e
);

    // slot[k] commits k+1 edges from now.
    wb_entry_t slot [DELAY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DELAY; k++) begin
                slot[k] <= '0;
            end
        end else begin
            slot[DELAY-1] <= in_e;
            for (int k = 0; k < DELAY - 1; k++) begin
                slot[k] <= slot[k+1];
            end
        end
    end

    assign out_e = slot[0];

endmodule

// File: rtl/dsw_regfile.sv
module dsw_regfile
    import dsw_pkg::*;
#(
    parameter int PORTS = NWP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    // Port PORTS-1 has highest priority (youngest instruction).
    input  wb_entry_t [PORTS-1:0]  wr,
    input  logic                   rd_file,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [XLEN-1:0]        rd_data
);

    localparam int DEPTH = 2 * NREG;

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int p = 0; p < PORTS; p++) begin
                if (wr[p].vld) begin
                    mem[{wr[p].file, wr[p].idx}] <= wr[p].val;
                end
            end
        end
    end

    assign rd_data = mem[{rd_file, rd_idx}];

endmodule

// File: rtl/dslot_wb_sched.sv
module dslot_wb_sched
    import dsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [CLS_W-1:0]  iss_cls,
    input  logic              iss_pred,
    input  logic              iss_file,
    input  logic [IDX_W-1:0]  iss_idx,
    input  logic [XLEN-1:0]   iss_data,
    input  logic [XLEN-1:0]   iss_target,
    input  logic              rd_file,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_addr
);

    logic      fire;
    wb_entry_t issue_e;
    wb_entry_t direct_e;
    wb_entry_t br_in;
    wb_entry_t br_out;
    wb_entry_t lane_in  [NLANE];
    wb_entry_t lane_out [NLANE];
    wb_entry_t [NWP-1:0] wr_ports;

    assign fire = iss_valid && iss_pred;

    always_comb begin
        issue_e      = '0;
        issue_e.file = iss_file;
        issue_e.idx  = iss_idx;
        issue_e.val  = iss_data;
    end

    always_comb begin
        direct_e     = issue_e;
        direct_e.vld = fire && (iss_cls == CLS_ALU);
    end

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            always_comb begin
                lane_in[g]     = issue_e;
                lane_in[g].vld = fire && (iss_cls == lane_class(g));
            end

            dsw_lane #(
                .DELAY (lane_delay(g))
            ) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .in_e  (lane_in[g]),
                .out_e (lane_out[g])
            );

            // Longest delay = oldest issue = lowest priority port.
            assign wr_ports[g] = lane_out[NLANE-1-g];
        end
    endgenerate

    assign wr_ports[NWP-1] = direct_e;

    dsw_regfile #(
        .PORTS (NWP)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ports),
        .rd_file (rd_file),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        br_in     = '0;
        br_in.vld = fire && (iss_cls == CLS_BRANCH);
        br_in.val = iss_target;
    end

    dsw_lane #(
        .DELAY (DLY_BR)
    ) u_br_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .in_e  (br_in),
        .out_e (br_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
        end else begin
            redir_valid <= br_out.vld;
            redir_addr  <= br_out.vld ? br_out.val : '0;
        end
    end

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker
    import dsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [CLS_W-1:0]  iss_cls,
    input  logic              iss_pred,
    input  logic              iss_file,
    input  logic [IDX_W-1:0]  iss_idx,
    input  logic [XLEN-1:0]   iss_data,
    input  logic [XLEN-1:0]   iss_target,
    input  logic              rd_file,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [XLEN-1:0]   rd_data,
    input  logic              redir_valid,
    input  logic [XLEN-1:0]   redir_addr
);

    logic [2:0] cyc;
    logic       br_iss;
    logic       alu_iss;
    logic       warm;

    assign br_iss  = iss_valid && iss_pred && (iss_cls == CLS_BRANCH);
    assign alu_iss = iss_valid && iss_pred && (iss_cls == CLS_ALU);
    assign warm    = (cyc == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cyc <= '0;
        else if (!warm)   cyc <= cyc + 3'd1;
    end

    assert_single_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alu_iss |=> (({rd_file, rd_idx} != $past({iss_file, iss_idx}))
                     || (rd_data == $past(iss_data))));

    assert_branch_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(br_iss, 6)) |-> (redir_valid && (redir_addr == $past(iss_target, 6))));

    assert_no_stray_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && redir_valid) |-> $past(br_iss, 6));

    assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < 3'd6) |-> !redir_valid);

endmodule

bind dslot_wb_sched dsw_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_cls     (iss_cls),
    .iss_pred    (iss_pred),
    .iss_file    (iss_file),
    .iss_idx     (iss_idx),
    .iss_data    (iss_data),
    .iss_target  (iss_target),
    .rd_file     (rd_file),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr)
);

// File: tb/dslot_wb_sched_tb.sv
module dslot_wb_sched_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [2:0]  iss_cls;
    logic        iss_pred;
    logic        iss_file;
    logic [4:0]  iss_idx;
    logic [31:0] iss_data;
    logic [31:0] iss_target;
    logic        rd_file;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        redir_valid;
    logic [31:0] redir_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [64];

    always #2 clk = ~clk;

    dslot_wb_sched u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .iss_pred(iss_pred), .iss_file(iss_file), .iss_idx(iss_idx),
        .iss_data(iss_data), .iss_target(iss_target), .rd_file(rd_file),
        .rd_idx(rd_idx), .rd_data(rd_data), .redir_valid(redir_valid),
        .redir_addr(redir_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_expect(input logic f, input logic [4:0] i, input logic [31:0] exp, input string req);
        rd_file = f;
        rd_idx  = i;
        #1;
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic redir_expect(input logic v, input logic [31:0] a, input string req);
        chk(redir_valid === v, req, {31'd0, redir_valid}, {31'd0, v});
        if (v) chk(redir_addr === a, req, redir_addr, a);
    endtask

    task automatic set_issue(input logic [2:0] c, input logic p, input logic f,
                             input logic [4:0] i, input logic [31:0] d, input logic [31:0] t);
        iss_valid = 1'b1; iss_cls = c; iss_pred = p; iss_file = f;
        iss_idx = i; iss_data = d; iss_target = t;
    endtask

    task automatic clr_issue();
        iss_valid = 1'b0; iss_cls = 3'd0; iss_pred = 1'b0; iss_file = 1'b0;
        iss_idx = '0; iss_data = '0; iss_target = '0;
    endtask

    // Issue one result of a class with d delay slots and watch the window.
    task automatic t_delay(input logic [2:0] c, input int d, input logic f,
                           input logic [4:0] i, input logic [31:0] v, input string req);
        logic [31:0] old;
        old = mdl[{f, i}];
        @(negedge clk); set_issue(c, 1'b1, f, i, v, '0);
        @(negedge clk); clr_issue();
        for (int k = 1; k <= d; k++) begin
            rd_expect(f, i, old, req);
            @(negedge clk);
        end
        rd_expect(f, i, v, req);
        mdl[{f, i}] = v;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            rd_expect(i[0], 5'(i * 9), 32'd0, "R10");
        end
        redir_expect(1'b0, '0, "R10");
    endtask

    task automatic t_classes();
        t_delay(3'd0, 0, 1'b0, 5'd4,  32'h0000_00A4, "R1");
        t_delay(3'd1, 1, 1'b0, 5'd5,  32'h0000_0011, "R2");
        t_delay(3'd2, 2, 1'b1, 5'd6,  32'h0000_0022, "R3");
        t_delay(3'd3, 4, 1'b1, 5'd31, 32'hDEAD_BEEF, "R4");
        t_delay(3'd3, 4, 1'b1, 5'd31, 32'h1234_5678, "R4");
    endtask

    task automatic t_squash();
        @(negedge clk); set_issue(3'd0, 1'b0, 1'b0, 5'd4, 32'hBAD0_0001, '0);
        @(negedge clk); set_issue(3'd3, 1'b0, 1'b0, 5'd4, 32'hBAD0_0002, '0);
        @(negedge clk); set_issue(3'd5, 1'b1, 1'b0, 5'd4, 32'hBAD0_0003, '0);
        @(negedge clk); set_issue(3'd7, 1'b1, 1'b0, 5'd4, 32'hBAD0_0004, '0);
        @(negedge clk); set_issue(3'd4, 1'b0, 1'b0, 5'd4, 32'hBAD0_0005, 32'hBAD0_0005);
        @(negedge clk); iss_valid = 1'b0; iss_pred = 1'b1; iss_cls = 3'd0;
        @(negedge clk); clr_issue();
        for (int k = 0; k < 8; k++) begin
            rd_expect(1'b0, 5'd4, mdl[{1'b0, 5'd4}], "R6");
            redir_expect(1'b0, '0, "R6");
            @(negedge clk);
        end
    endtask

    task automatic t_branch();
        @(negedge clk); set_issue(3'd4, 1'b1, 1'b0, 5'd0, '0, 32'h0000_1000);
        @(negedge clk); clr_issue();
        for (int k = 1; k <= 7; k++) begin
            redir_expect(k == 6, 32'h0000_1000, "R5");
            @(negedge clk);
        end
    endtask

    task automatic t_two_branches();
        @(negedge clk); set_issue(3'd4, 1'b1, 1'b0, 5'd0, '0, 32'h0000_2000);
        @(negedge clk); clr_issue();
        @(negedge clk); set_issue(3'd4, 1'b1, 1'b0, 5'd0, '0, 32'h0000_3000);
        @(negedge clk); clr_issue();
        // Now in cycle t+3.
        for (int k = 3; k <= 9; k++) begin
            if (k == 6)      redir_expect(1'b1, 32'h0000_2000, "R9");
            else if (k == 8) redir_expect(1'b1, 32'h0000_3000, "R9");
            else             redir_expect(1'b0, '0, "R9");
            @(negedge clk);
        end
    endtask

    task automatic t_collide();
        logic [31:0] old;
        // Load at t, slow multiply at t+2, multiply at t+3: all commit on one edge.
        old = mdl[{1'b1, 5'd3}];
        @(negedge clk); set_issue(3'd3, 1'b1, 1'b1, 5'd3, 32'h0000_0333, '0);
        @(negedge clk); clr_issue();
        @(negedge clk); set_issue(3'd2, 1'b1, 1'b1, 5'd3, 32'h0000_0222, '0);
        @(negedge clk); set_issue(3'd1, 1'b1, 1'b1, 5'd3, 32'h0000_0111, '0);
        @(negedge clk); clr_issue();
        rd_expect(1'b1, 5'd3, old, "R7");
        @(negedge clk);
        rd_expect(1'b1, 5'd3, 32'h0000_0111, "R7");
        mdl[{1'b1, 5'd3}] = 32'h0000_0111;
        // Load at t, single-cycle at t+4 on the same register.
        @(negedge clk); set_issue(3'd3, 1'b1, 1'b1, 5'd8, 32'h0000_0888, '0);
        @(negedge clk); clr_issue();
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); set_issue(3'd0, 1'b1, 1'b1, 5'd8, 32'h0000_0999, '0);
        @(negedge clk); clr_issue();
        rd_expect(1'b1, 5'd8, 32'h0000_0999, "R7");
        @(negedge clk);
        rd_expect(1'b1, 5'd8, 32'h0000_0999, "R7");
        mdl[{1'b1, 5'd8}] = 32'h0000_0999;
    endtask

    task automatic t_files();
        @(negedge clk); set_issue(3'd0, 1'b1, 1'b0, 5'd9, 32'hAAAA_0009, '0);
        @(negedge clk); set_issue(3'd0, 1'b1, 1'b1, 5'd9, 32'hBBBB_0009, '0);
        @(negedge clk); clr_issue();
        rd_expect(1'b0, 5'd9, 32'hAAAA_0009, "R8");
        rd_expect(1'b1, 5'd9, 32'hBBBB_0009, "R8");
        mdl[{1'b0, 5'd9}] = 32'hAAAA_0009;
        mdl[{1'b1, 5'd9}] = 32'hBBBB_0009;
    endtask

    task automatic t_overlap();
        logic [31:0] old1;
        old1 = mdl[{1'b0, 5'd1}];
        @(negedge clk); set_issue(3'd3, 1'b1, 1'b0, 5'd1, 32'h0000_00A1, '0);
        @(negedge clk); set_issue(3'd1, 1'b1, 1'b0, 5'd2, 32'h0000_00A2, '0);
        @(negedge clk); set_issue(3'd0, 1'b1, 1'b0, 5'd3, 32'h0000_00A3, '0);
        @(negedge clk); clr_issue();
        // Cycle t+3.
        rd_expect(1'b0, 5'd3, 32'h0000_00A3, "R11");
        rd_expect(1'b0, 5'd2, 32'h0000_00A2, "R11");
        rd_expect(1'b0, 5'd1, old1, "R11");
        @(negedge clk);
        @(negedge clk);
        // Cycle t+5.
        rd_expect(1'b0, 5'd1, 32'h0000_00A1, "R11");
        rd_expect(1'b0, 5'd2, 32'h0000_00A2, "R11");
        mdl[{1'b0, 5'd1}] = 32'h0000_00A1;
        mdl[{1'b0, 5'd2}] = 32'h0000_00A2;
        mdl[{1'b0, 5'd3}] = 32'h0000_00A3;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        clr_issue();
        rd_file = 1'b0;
        rd_idx  = '0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classes();
        t_squash();
        t_branch();
        t_two_branches();
        t_collide();
        t_files();
        t_overlap();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule